// File: doc/BRIEF.md
# Coherent Event Tally with Captured Readout

This block counts pulses that arrive on an input not timed by the system clock. A reader gets a value that cannot be torn: no half-updated pattern such as a skewed step from 0x000F to 0x0010. The block never lets the reader look at the running tally. The tally lives in one register. A second register receives a copy of it only when a read strobe, synchronous to the system clock, is sampled high. The copy stays frozen until the next strobe.

The event line first passes through a two-flop synchroniser. A third flop then marks each low-to-high transition as a one-cycle count enable. A direction input, sampled in the same cycle as that enable, selects whether the tally goes up or down. The tally wraps modulo 2^WIDTH in both directions.

Each strobe copies the tally into the holding register and starts a new interval. A rising edge that lands in the strobe cycle is carried into the new interval rather than lost. The caller reads `held_q` whenever `held_vld` shows that a fresh capture has just arrived.

Top module: `evt_snapshot_counter`

## Requirements
- R1: After reset, `held_q` is 0, `held_vld` is 0, and the running tally is 0, so a strobe issued before any event captures 0.
- R2: Each low-to-high transition of `evt_in` changes the tally exactly once. Holding `evt_in` high, or holding it low, adds nothing further.
- R3: With `count_down` = 0 the tally adds 1 per event. With `count_down` = 1 it subtracts 1. Both directions wrap modulo 2^16, so one down event from 0 gives 0xFFFF.
- R4: A rise of `evt_in` first sampled at clock edge k updates the tally at edge k+2. A strobe at edge k+1 does not yet include that event.
- R5: `held_q` changes only at a clock edge where `rd_stb` is high. At that edge it loads the tally accumulated before that edge, and it then holds that value until the next strobe.
- R6: A strobe with no coincident event restarts the tally at 0.
- R7: A strobe at the same edge as a counted event restarts the tally at 1 when `count_down` = 0, or at 0xFFFF when `count_down` = 1. The event is not lost.
- R8: `held_vld` is high for exactly the one cycle after each edge at which `rd_stb` was sampled high, and is low otherwise.
- R9: The direction that applies to an event is the value of `count_down` at the edge where that event is counted, not its value when `evt_in` rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| evt_in | input | 1 | Event line, asynchronous to `clk` |
| count_down | input | 1 | Direction select: 1 subtracts, 0 adds |
| rd_stb | input | 1 | Synchronous capture strobe |
| held_q | output | 16 | Frozen tally from the last strobe |
| held_vld | output | 1 | One-cycle flag that follows each capture |

## Verification
A tally that is wrong inside the block stays hidden until the next strobe. It then appears in `held_q` one edge after `rd_stb` is sampled high, so every check strobes and compares the captured value.

A dropped coincident event, or a wrong restart value, does not show in the interval where it happens. It surfaces only at the strobe after that. The bench therefore follows each coincidence case with an event-free interval and checks for exactly 1 or 0xFFFF.

A register that should be frozen but is not shows as `held_q` moving between strobes. The bench checks for this while events are still arriving.

// File: rtl/evt_snapshot_counter.sv
module evt_snapshot_counter #(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic             count_down,
  input  logic             rd_stb,
  output logic [WIDTH-1:0] held_q,
  output logic             held_vld
);

  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   hit;
  logic [WIDTH-1:0]       tally_q;
  logic [WIDTH-1:0]       step;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end

  assign hit  = sync_q[SYNC_STAGES-1] & ~last_q;
  assign step = count_down ? ONES : ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tally_q  <= '0;
      held_q   <= '0;
      held_vld <= 1'b0;
    end else begin
      held_vld <= rd_stb;
      if (rd_stb) begin
        held_q  <= tally_q;
        tally_q <= hit ? step : '0;
      end else if (hit) begin
        tally_q <= tally_q + step;
      end
    end

  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(held_q));
  assert_capture_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> held_q == $past(tally_q));
  assert_vld_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> held_vld);
  assert_vld_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !held_vld);
  assert_idle_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !hit) |=> $stable(tally_q));
  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && hit && !count_down) |=> tally_q == $past(tally_q) + ONE);
  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && hit && count_down) |=> tally_q == $past(tally_q) - ONE);
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !hit) |=> tally_q == '0);
  assert_restart_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && hit) |=> tally_q == (count_down ? ONES : ONE));
  assert_hit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: tb/sim_evt_snapshot_counter.sv
module sim_evt_snapshot_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_in = 1'b0;
  logic count_down = 1'b0;
  logic rd_stb = 1'b0;
  logic [15:0] held_q;
  logic held_vld;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_snapshot_counter u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .count_down(count_down),
    .rd_stb(rd_stb), .held_q(held_q), .held_vld(held_vld)
  );

  localparam int NV = 6;
  localparam int unsigned VN[NV] = '{3, 0, 1, 5, 17, 2};
  localparam bit VD[NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [15:0] VE[NV] = '{16'h0003, 16'h0000, 16'hFFFF,
                                     16'hFFFB, 16'h0011, 16'hFFFE};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit dn);
    @(negedge clk); evt_in = 1'b1; count_down = dn;
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe(input string req, input logic [15:0] exp);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk(req, {16'h0, held_q}, {16'h0, exp});
    chk("R8 vld high", {31'h0, held_vld}, 32'h1);
    @(negedge clk);
    chk("R8 vld low", {31'h0, held_vld}, 32'h0);
  endtask

  initial begin
    repeat (3000) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held reset", {16'h0, held_q}, 32'h0);
    chk("R1 vld reset", {31'h0, held_vld}, 32'h0);
    strobe("R1 tally reset", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VN[i]); k++) pulse(VD[i]);
      strobe("R2 R3 R6 table", VE[i]);
    end

    // R5: held value frozen while events accumulate
    pulse(1'b0); pulse(1'b0);
    chk("R5 frozen", {16'h0, held_q}, {16'h0, 16'hFFFE});
    strobe("R5 capture", 16'h0002);

    // R7/R4: event counted at the strobe edge goes to new interval (up)
    pulse(1'b0);
    @(negedge clk); evt_in = 1'b1; count_down = 1'b0;
    @(negedge clk);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R7 coincide old", {16'h0, held_q}, 32'h1);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
    strobe("R7 carried up", 16'h0001);

    // R7 down
    @(negedge clk); evt_in = 1'b1; count_down = 1'b1;
    @(negedge clk);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R7 coincide old down", {16'h0, held_q}, 32'h0);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
    strobe("R7 carried down", 16'hFFFF);

    // R4: strobe one edge before the counting edge misses the event
    @(negedge clk); evt_in = 1'b1; count_down = 1'b0;
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R4 early strobe", {16'h0, held_q}, 32'h0);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
    strobe("R4 counted later", 16'h0001);

    // R2: long high level counts once
    @(negedge clk); evt_in = 1'b1; count_down = 1'b0;
    repeat (20) @(negedge clk);
    evt_in = 1'b0;
    repeat (3) @(negedge clk);
    strobe("R2 level once", 16'h0001);

    // R9: direction taken at counting edge, not at rise
    @(negedge clk); evt_in = 1'b1; count_down = 1'b0;
    @(negedge clk);
    @(negedge clk); count_down = 1'b1;
    @(negedge clk); count_down = 1'b0; evt_in = 1'b0;
    repeat (3) @(negedge clk);
    strobe("R9 direction", 16'hFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule